// File: doc/BRIEF.md
# Retro Chipset Clock-Enable Generator

This block takes one master clock of about 28.375 MHz and derives, from a small chain of counters, the timing strobes a retro home-computer chipset needs: a 7 MHz one-cycle enable, a second 7 MHz enable on the opposite half of the same 7 MHz period, a pair of 7 MHz phase levels a quarter period apart, a colour-clock level at one eighth of the master rate (about 3.54 MHz), and a slow peripheral enable at one fortieth of the master rate (about 0.709 MHz). Every output lives in the master clock domain, so downstream logic clocks on the master clock and qualifies its registers with these strobes.

A synchronous active-low reset puts every counter in a fixed phase. It holds all outputs low while asserted. The first master cycle after release is always the first cycle of a 7 MHz period. Asserting reset again at any time restarts the whole family with the same alignment, so all enables keep a fixed, known phase relation to each other.

Top module: `retro_clken_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six outputs are low in the following cycle.
- R2: `en_main` is high for exactly one master cycle out of every 4. Its first pulse is in the first cycle after `rst_n` is released.
- R3: `en_opp` is a one-cycle pulse exactly 2 master cycles after each `en_main` pulse, and never coincides with it.
- R4: `ph_lead` is high in each `en_main` cycle and in the cycle after it, and low for the other 2 cycles of the period.
- R5: `ph_lag` equals `ph_lead` delayed by one master cycle (a 90-degree lag at the 7 MHz rate). It is low in the first cycle after reset release.
- R6: `cc_lvl` is low after reset and toggles at the end of every `en_main` cycle, giving a square wave whose rising edges are 8 master cycles apart.
- R7: `en_slow` is a one-cycle pulse that coincides with every tenth `en_main` pulse. Its first pulse is at the tenth `en_main` after reset, and later pulses are spaced 40 master cycles apart.
- R8: Reset asserted in the middle of a run restarts every output sequence with the same alignment as after power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, about 28.375 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| en_main | output | 1 | 7 MHz enable, one cycle in four |
| en_opp | output | 1 | 7 MHz enable on the opposite half period |
| ph_lead | output | 1 | 7 MHz phase level, high for half the period starting at `en_main` |
| ph_lag | output | 1 | `ph_lead` lagging by one master cycle |
| cc_lvl | output | 1 | Colour-clock level, master divided by 8 |
| en_slow | output | 1 | Slow peripheral enable, one cycle in forty |

## Verification
A phase counter that skips or repeats a state shows up within 4 master cycles. `en_main`, `en_opp` and the phase pair all decode that one counter, so all four move off their slots together. A colour-clock register in the wrong state shows as an inverted level from the next cycle, and a slow divider that is off by one moves `en_slow` away from its 40-cycle slot. That error can take up to 40 cycles to show, so the run covers several slow periods before and after a mid-run reset placed off a period boundary.

// File: rtl/rcg_pkg.sv
// Package: shared types for the retro clock-enable generator.
// Assumes nothing beyond a single master clock domain.
package rcg_pkg;

    // Decoded strobes and levels of one sub-period phase
    typedef struct packed {
        logic en_main;
        logic en_opp;
        logic ph_lead;
        logic ph_lag;
    } rcg_phase_t;

endpackage

// File: rtl/rcg_phase_ctr.sv
// Phase counter: counts master cycles modulo PHASES.
// Reset loads the last state, so that the first cycle after release is phase 0.
module rcg_phase_ctr #(
    parameter int PHASES = 4,
    localparam int W     = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] phase
);
    localparam logic [W-1:0] LAST = W'(PHASES - 1);

    // Advance the phase each master cycle and wrap after LAST
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= LAST;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end
endmodule

// File: rtl/rcg_phase_decode.sv
// Phase decoder: turns the phase count into the two enables and the
// quadrature level pair. Assumes PHASES is a multiple of 4, so that a
// quarter period is a whole number of master cycles.
module rcg_phase_decode
    import rcg_pkg::*;
#(
    parameter int PHASES = 4,
    localparam int W     = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic [W-1:0] phase,
    output rcg_phase_t   dec
);
    localparam logic [W-1:0] HALF    = W'(PHASES / 2);
    localparam logic [W-1:0] QTR     = W'(PHASES / 4);
    localparam logic [W-1:0] LAG_END = W'(PHASES / 4 + PHASES / 2);

    // Decode the strobe slots and the level windows from the phase
    always_comb begin
        dec.en_main = (phase == '0);
        dec.en_opp  = (phase == HALF);
        dec.ph_lead = (phase < HALF);
        dec.ph_lag  = (phase >= QTR) && (phase < LAG_END);
    end
endmodule

// File: rtl/rcg_toggle.sv
// Colour-clock stage: a level that toggles on every advance strobe.
// Starts low after reset.
module rcg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic lvl
);
    // Flip the level at the end of each advance cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   lvl <= 1'b0;
        else if (adv) lvl <= ~lvl;
    end
endmodule

// File: rtl/rcg_slow_div.sv
// Slow divider: counts advance strobes modulo DIV and marks the strobe
// that completes each group of DIV. Assumes adv is a single-cycle pulse.
module rcg_slow_div #(
    parameter int DIV = 10,
    localparam int W  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic pulse
);
    localparam logic [W-1:0] TOP = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Count advance strobes and wrap after TOP
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (adv)   cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end

    // Pulse on the advance strobe that wraps the count
    assign pulse = adv && (cnt == TOP);
endmodule

// File: rtl/retro_clken_gen.sv
// Retro clock-enable generator top: one phase counter feeds the 7 MHz
// enables and phase pair, a toggle stage makes the colour clock, and a
// divider on the 7 MHz enable makes the slow peripheral enable.
// Assumes a single master clock and a synchronous active-low reset.
module retro_clken_gen
    import rcg_pkg::*;
#(
    parameter int PHASES   = 4,
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic en_main,
    output logic en_opp,
    output logic ph_lead,
    output logic ph_lag,
    output logic cc_lvl,
    output logic en_slow
);
    localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;

    logic [PW-1:0] phase;
    rcg_phase_t    dec;

    rcg_phase_ctr #(.PHASES(PHASES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    rcg_phase_decode #(.PHASES(PHASES)) u_dec (
        .phase (phase),
        .dec   (dec)
    );

    rcg_toggle u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (dec.en_main),
        .lvl   (cc_lvl)
    );

    rcg_slow_div #(.DIV(SLOW_DIV)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (dec.en_main),
        .pulse (en_slow)
    );

    // Route the decoded strobes to the ports
    always_comb begin
        en_main = dec.en_main;
        en_opp  = dec.en_opp;
        ph_lead = dec.ph_lead;
        ph_lag  = dec.ph_lag;
    end
endmodule

// File: rtl/retro_clken_gen_chk.sv
// Checker: temporal properties of the generator outputs, bound to the top.
module retro_clken_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en_main,
    input logic en_opp,
    input logic ph_lead,
    input logic ph_lag,
    input logic cc_lvl,
    input logic en_slow
);
    AST_MAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_main |=> !en_main); // R2
    AST_OPP_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        en_main |=> ##1 en_opp); // R3
    AST_OPP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_main, en_opp})); // R3
    AST_LEAD_AT_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        en_main |=> ph_lead); // R4
    AST_LAG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ph_lag == $past(ph_lead))); // R5
    AST_CC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_main |=> (cc_lvl != $past(cc_lvl))); // R6
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_main && $past(rst_n)) |=> $stable(cc_lvl)); // R6
    AST_SLOW_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        en_slow |-> en_main); // R7
endmodule

bind retro_clken_gen retro_clken_gen_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_main (en_main),
    .en_opp  (en_opp),
    .ph_lead (ph_lead),
    .ph_lag  (ph_lag),
    .cc_lvl  (cc_lvl),
    .en_slow (en_slow)
);

// File: tb/retro_clken_gen_tb_top.sv
// Bench: behavioural cycle model compared on every falling edge, plus
// interval measurements between output pulses.
module retro_clken_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_main, en_opp, ph_lead, ph_lag, cc_lvl, en_slow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Cycles since reset release; -1 while in reset
    int k = -1;
    int last_main = -1, last_cc = -1, last_slow = -1;
    logic prev_cc = 1'b0;
    bit   saw_reset = 1'b0;

    always #2.5 clk = ~clk;

    retro_clken_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .en_main(en_main), .en_opp(en_opp),
        .ph_lead(ph_lead), .ph_lag(ph_lag),
        .cc_lvl(cc_lvl), .en_slow(en_slow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    // Model time base: follows the reset value seen at each rising edge
    always @(posedge clk) begin
        if (!rst_n) k <= -1;
        else        k <= k + 1;
    end

    // Compare the outputs with the model in the middle of each cycle
    always @(negedge clk) begin
        if (k < 0) begin
            if (saw_reset) begin
                chk("R1 en_main", en_main, 0); chk("R1 en_opp", en_opp, 0);
                chk("R1 ph_lead", ph_lead, 0); chk("R1 ph_lag", ph_lag, 0);
                chk("R1 cc_lvl", cc_lvl, 0);   chk("R1 en_slow", en_slow, 0);
            end
            last_main = -1; last_cc = -1; last_slow = -1; prev_cc = 1'b0;
        end else begin
            int p;
            p = k % 4;
            chk("R2 en_main", en_main, int'(p == 0));
            chk("R3 en_opp", en_opp, int'(p == 2));
            chk("R4 ph_lead", ph_lead, int'(p < 2));
            chk("R5 ph_lag", ph_lag, int'(p == 1 || p == 2));
            chk("R6 cc_lvl", cc_lvl, ((k + 3) / 4) % 2);
            chk("R7 en_slow", en_slow, int'(p == 0 && ((k / 4) % 10) == 9));
            if (en_main) begin
                if (last_main >= 0) chk("R2 en_main interval", k - last_main, 4);
                last_main = k;
            end
            if (cc_lvl && !prev_cc) begin
                if (last_cc >= 0) chk("R6 cc_lvl rise interval", k - last_cc, 8);
                last_cc = k;
            end
            if (en_slow) begin
                if (last_slow >= 0) chk("R7 en_slow interval", k - last_slow, 40);
                last_slow = k;
            end
            prev_cc = cc_lvl;
        end
    end

    // Stimulus: power-up reset, long run, mid-run reset (R8), second run
    initial begin
        repeat (2) @(posedge clk);
        saw_reset = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (203) @(posedge clk);
        #1 rst_n = 1'b0;          // R8: restart off a period boundary
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (170) @(posedge clk);
        done = 1'b1;
    end

    // Finish on completion or on the watchdog
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule